// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial side of a bus-to-SPI bridge. An 8-bit configuration word selects clock polarity, clock phase, bit order and one of four fixed SCK dividers of the system clock. After a start pulse with a nonzero byte count, the engine walks a local buffer from address 0 upward. It fetches each byte through the buffer read port and shifts it out on MOSI. At the same time it shifts in MISO and writes the received byte back to the address the transmitted byte came from. The buffer therefore holds the reply once the transfer ends.

The buffer read port is asynchronous: `buf_rdata` must show the contents at `buf_addr` in the same cycle. Writes use `buf_we` with `buf_addr` and `buf_wdata`. Chip-select policy, the host-side interface and the storage itself live outside this block. While a transfer runs, `busy` is high and the configuration is frozen.

Top module: `spi_shift_master`

## Requirements
- R1: The configuration word sets the SCK half-period in system cycles from bits [1:0]: 00 gives 2, 01 gives 8, 10 gives 32 and 11 gives 64. These are full periods of 4, 16, 64 and 128 cycles. Consecutive SCK edges within one byte are exactly one half-period apart.
- R2: Whenever `busy` is low, `sck` equals configuration bit 3 (CPOL). It is 0 after reset, because the configuration resets to 0x00.
- R3: A start pulse with a nonzero count, seen while idle, raises `busy` on the next cycle. A start seen while busy has no effect on the running transfer.
- R4: A start with a count of zero never raises `busy` and produces no SCK edge.
- R5: Each byte takes exactly 8 bits and 16 SCK edges. A transfer of N bytes produces 16·N edges and serves buffer addresses 0 to N−1 in order.
- R6: With configuration bit 2 (CPHA) clear, the first bit is on MOSI before the first leading edge, both sides sample on leading edges and data changes on trailing edges. With CPHA set, data changes on leading edges and is sampled on trailing edges.
- R7: With configuration bit 5 clear, bit 7 of each byte goes out and comes in first. With bit 5 set, bit 0 is first.
- R8: The byte received in slot i is written to buffer address i with a one-cycle `buf_we` pulse, and only while busy.
- R9: `busy` falls exactly half-period + 1 system cycles after the final SCK edge of the transfer.
- R10: A configuration write while busy is dropped. The running transfer and later transfers use the previous configuration until a write lands while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration word: [1:0] divider, [2] CPHA, [3] CPOL, [5] LSB first |
| start | input | 1 | Start pulse |
| byte_count | input | CNT_W | Number of bytes to exchange |
| buf_addr | output | CNT_W | Buffer address for read and write-back |
| buf_rdata | input | 8 | Buffer data at buf_addr (same cycle) |
| buf_we | output | 1 | Write-back strobe |
| buf_wdata | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A configuration write can arrive in the same cycle as an active transfer, and so can a fresh start request. The bench provokes both by pulsing `cfg_write` (with a different divider and polarity) and `start` (with a larger count) in one cycle in the middle of a two-byte exchange. It judges the outcome at the pins. The SCK half-period must stay at its old value, and the edge count must stay at 32. SCK must come back to the old idle level. A following transfer without a new write must still run at the old setting. All 32 combinations of divider, phase, polarity and order are also swept against a bench-side SPI slave.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int WORD_W = 8;
  localparam int HALF_W = 7;

  typedef struct packed {
    logic [1:0] spare_hi;
    logic       lsb_first;
    logic       spare_mid;
    logic       cpol;
    logic       cpha;
    logic [1:0] div_sel;
  } spi_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_SHIFT, ST_WB, ST_TAIL
  } eng_state_t;

  // SCK half-period in system cycles for each divider code
  function automatic logic [HALF_W-1:0] half_cycles(input logic [1:0] sel);
    case (sel)
      2'd0:    half_cycles = 7'd2;
      2'd1:    half_cycles = 7'd8;
      2'd2:    half_cycles = 7'd32;
      default: half_cycles = 7'd64;
    endcase
  endfunction

  function automatic logic out_bit(input logic [WORD_W-1:0] b, input logic lsb);
    out_bit = lsb ? b[0] : b[WORD_W-1];
  endfunction

  function automatic logic [WORD_W-1:0] tx_shift(input logic [WORD_W-1:0] b, input logic lsb);
    tx_shift = lsb ? {1'b0, b[WORD_W-1:1]} : {b[WORD_W-2:0], 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] rx_shift(input logic [WORD_W-1:0] b, input logic d,
                                                 input logic lsb);
    rx_shift = lsb ? {d, b[WORD_W-1:1]} : {b[WORD_W-2:0], d};
  endfunction
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick
  import spi_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] limit;

  assign limit = half_cycles(div_sel) - 7'd1;
  assign tick  = en && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 7'd1;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              drive,
  input  logic              sample,
  input  logic              lsb_first,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_byte
);
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] tx_src;

  assign tx_src = load ? load_data : tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      mosi    <= 1'b0;
      rx_byte <= '0;
    end else begin
      if (drive) begin
        mosi <= out_bit(tx_src, lsb_first);
        tx_q <= tx_shift(tx_src, lsb_first);
      end else if (load) begin
        tx_q <= load_data;
      end
      if (sample) rx_byte <= rx_shift(rx_byte, miso, lsb_first);
    end
  end
endmodule

// File: rtl/spi_shift_master.sv
module spi_shift_master
  import spi_eng_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_data,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  output logic [CNT_W-1:0]  buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              buf_we,
  output logic [7:0]        buf_wdata,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int EDGE_W = $clog2(2 * WORD_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * WORD_W - 1);

  eng_state_t       state;
  spi_cfg_t         cfg_q;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] remaining;
  logic [EDGE_W-1:0] edge_cnt;
  logic             phase;

  // named internal events
  logic half_tick, tick_en, start_accept, cfg_accept;
  logic load_evt, drive_evt, sample_evt, final_edge, trailing;
  logic [WORD_W-1:0] rx_byte;

  assign start_accept = start && (state == ST_IDLE) && (byte_count != '0);
  assign cfg_accept   = cfg_we && (state == ST_IDLE);
  assign tick_en      = (state == ST_SHIFT) || (state == ST_TAIL);
  assign load_evt     = (state == ST_LOAD);
  assign trailing     = edge_cnt[0];
  assign final_edge   = half_tick && (state == ST_SHIFT) && (edge_cnt == LAST_EDGE);
  assign drive_evt    = (load_evt && !cfg_q.cpha) ||
                        (half_tick && (state == ST_SHIFT) &&
                         (cfg_q.cpha ? !trailing : (trailing && edge_cnt != LAST_EDGE)));
  assign sample_evt   = half_tick && (state == ST_SHIFT) && (cfg_q.cpha ? trailing : !trailing);

  spi_half_tick u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tick_en),
    .div_sel (cfg_q.div_sel),
    .tick    (half_tick)
  );

  spi_byte_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_evt),
    .load_data (buf_rdata),
    .drive     (drive_evt),
    .sample    (sample_evt),
    .lsb_first (cfg_q.lsb_first),
    .miso      (miso),
    .mosi      (mosi),
    .rx_byte   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cfg_q     <= '0;
      idx       <= '0;
      remaining <= '0;
      edge_cnt  <= '0;
      phase     <= 1'b0;
    end else begin
      if (cfg_accept) cfg_q <= spi_cfg_t'(cfg_data);
      case (state)
        ST_IDLE: if (start_accept) begin
          state     <= ST_LOAD;
          idx       <= '0;
          remaining <= byte_count;
        end
        ST_LOAD: begin
          state    <= ST_SHIFT;
          edge_cnt <= '0;
        end
        ST_SHIFT: if (half_tick) begin
          phase    <= ~phase;
          edge_cnt <= edge_cnt + 1'b1;
          if (final_edge) state <= ST_WB;
        end
        ST_WB: begin
          remaining <= remaining - 1'b1;
          if (remaining == CNT_W'(1)) begin
            state <= ST_TAIL;
          end else begin
            state <= ST_LOAD;
            idx   <= idx + 1'b1;
          end
        end
        ST_TAIL: if (half_tick) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign sck       = phase ^ cfg_q.cpol;
  assign buf_addr  = idx;
  assign buf_we    = (state == ST_WB);
  assign buf_wdata = rx_byte;
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] byte_count,
  input logic             busy,
  input logic             sck,
  input logic             buf_we,
  input logic [7:0]       cfg_word,
  input logic             half_tick
);
  assert_sck_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sck)) |-> $past(half_tick));

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cfg_word[3]));

  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count != '0) |=> busy);

  assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && byte_count == '0) |=> !busy);

  assert_we_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> busy);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_word));
endmodule

bind spi_shift_master spi_shift_master_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .byte_count (byte_count),
  .busy       (busy),
  .sck        (sck),
  .buf_we     (buf_we),
  .cfg_word   (cfg_q),
  .half_tick  (half_tick)
);

// File: tb/test_spi_shift_master.sv
module test_spi_shift_master;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [7:0]       cfg_data = '0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [CNT_W-1:0] buf_addr;
  logic [7:0]       buf_rdata;
  logic             buf_we;
  logic [7:0]       buf_wdata;
  logic             busy, sck, mosi;
  logic             miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] mem [0:255];
  assign buf_rdata = mem[buf_addr];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (buf_we) mem[buf_addr] <= buf_wdata;
  end

  spi_shift_master #(.CNT_W(CNT_W)) i_spi_shift_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .start(start), .byte_count(byte_count), .buf_addr(buf_addr),
    .buf_rdata(buf_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .busy(busy), .sck(sck), .mosi(mosi), .miso(miso)
  );

  // bench-side SPI slave
  logic       s_cpha = 0, s_cpol = 0, s_lsb = 0;
  logic [7:0] s_tx [0:7];
  logic [7:0] s_rx [0:7];
  int s_rcount = 0, s_dcount = 0, edge_total = 0, last_edge_cyc = 0, gap_bad = 0, exp_half = 2;
  logic prev_sck = 0, prev_busy = 0;

  function automatic int bitpos(int k);
    return s_lsb ? (k % 8) : (7 - (k % 8));
  endfunction

  always @(negedge clk) begin
    logic leading;
    if (busy && !prev_busy && !s_cpha) begin
      miso = s_tx[0][bitpos(0)];
      s_dcount = 1;
    end
    if (busy && (sck !== prev_sck)) begin
      leading = (sck != s_cpol);
      if ((edge_total % 16) != 0 && (cyc - last_edge_cyc) != exp_half) gap_bad++;
      if ((leading != s_cpha) && s_rcount < 64) begin
        s_rx[s_rcount / 8][bitpos(s_rcount)] = mosi;
        s_rcount++;
      end
      if ((s_cpha ? leading : !leading) && s_dcount < 64) begin
        miso = s_tx[s_dcount / 8][bitpos(s_dcount)];
        s_dcount++;
      end
      edge_total++;
      last_edge_cyc = cyc;
    end
    prev_sck = sck;
    prev_busy = busy;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] d);
    return (d == 2'd3) ? 64 : (2 << (2 * d));
  endfunction

  task automatic run_xfer(input logic [7:0] cfg, input int n, input bit wr_cfg,
                          input bit inject, input logic [7:0] eff);
    if (wr_cfg) begin
      @(negedge clk); cfg_we = 1; cfg_data = cfg;
      @(negedge clk); cfg_we = 0;
    end
    s_cpha = eff[2]; s_cpol = eff[3]; s_lsb = eff[5];
    exp_half = half_of(eff[1:0]);
    for (int i = 0; i < 8; i++) begin
      mem[i]  = 8'(eff * 37 + i * 91 + 5);
      s_tx[i] = 8'(~(eff * 37 + i * 91 + 5) ^ (i * 13 + 1));
      s_rx[i] = '0;
    end
    s_rcount = 0; s_dcount = 0; edge_total = 0; gap_bad = 0;
    @(negedge clk);
    chk(sck == eff[3], "R2 idle sck level", sck, eff[3]);
    start = 1; byte_count = CNT_W'(n);
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R3 busy one cycle after start", busy, 1);
    if (inject) begin
      repeat (20) @(negedge clk);
      cfg_we = 1; cfg_data = eff ^ 8'h09; start = 1; byte_count = 5;
      @(negedge clk);
      cfg_we = 0; start = 0;
    end
    while (busy) @(negedge clk);
    chk(cyc - last_edge_cyc == exp_half + 1, "R9 busy fall after last edge",
        cyc - last_edge_cyc, exp_half + 1);
    chk(edge_total == 16 * n, inject ? "R3/R10 edge count" : "R5 edge count",
        edge_total, 16 * n);
    chk(gap_bad == 0, inject ? "R10 half-period kept" : "R1 half-period", gap_bad, 0);
    chk(sck == eff[3], "R2 sck after transfer", sck, eff[3]);
    for (int i = 0; i < n; i++) begin
      chk(s_rx[i] == 8'(eff * 37 + i * 91 + 5), "R6/R7 slave got byte", s_rx[i],
          8'(eff * 37 + i * 91 + 5));
      chk(mem[i] == s_tx[i], "R8 write-back in place", mem[i], s_tx[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic s0;
    bit saw;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R3 reset busy", busy, 0);
    chk(sck == 0, "R2 reset sck", sck, 0);
    chk(buf_we == 0, "R8 reset write strobe", buf_we, 0);

    // R1 R5 R6 R7 R8 R9: every divider, phase, polarity and order
    for (int v = 0; v < 32; v++) begin
      logic [7:0] c;
      c = {2'b00, v[4], 1'b0, v[3], v[2], v[1:0]};
      run_xfer(c, 3, 1, 0, c);
    end

    // R4: zero count
    s0 = sck; saw = 0;
    @(negedge clk); start = 1; byte_count = 0;
    @(negedge clk); start = 0;
    for (int i = 0; i < 40; i++) begin
      if (busy || sck != s0) saw = 1;
      @(negedge clk);
    end
    chk(saw == 0, "R4 zero count no busy, no edge", saw, 0);

    // R10 and R3: config write and start while busy are ignored
    run_xfer(8'h01, 2, 1, 1, 8'h01);
    run_xfer(8'h00, 2, 0, 0, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule